// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that works through a queue of up to sixteen byte transfers without processor help. Every queue slot has a byte to send, a byte that was received, and a command byte. The command byte picks the device to select and says whether the chip select stays low into the next slot. Software loads the slots over a simple 32-bit word-addressed register bus. It then writes the first and last slot numbers and sets a start bit. The engine shifts each slot out in turn, MSB first and in SPI mode 0, and stores what it reads from MISO. When the last slot is done it clears the start bit and raises a done flag.

A chip-select session can also outlive a single run. A hold bit in the control register, or a separate lock register, keeps the selected device low after the final slot. A later run then continues the same SPI transaction. This lets transfers longer than the queue be sent as one transaction.

SCK is the system clock divided by 2·`HALF_DIV`. It rests low whenever no run is in progress.

Top module: `spiq_master`

## Requirements
- R1: After reset, cs_n reads 4'hF, sck is 0, and control (word 0x02), status (word 0x03) and the current-slot register (word 0x04) all read 0.
- R2: Bus timing is mode 0, MSB first, 8 bits per slot. Each SCK half period lasts `HALF_DIV` clocks. The first rising edge of a slot comes one half period after that slot's low phase begins, and MOSI holds the current bit through both halves.
- R3: The transmit byte of slot i is written at word 0x20+2i. Bits are sampled on each rising SCK edge, and the received byte of slot i is read at word 0x40+2i+1.
- R4: Command byte i sits at word 0x60+i. Its bits 3:0 drive cs_n for the whole of slot i.
- R5: If bit 7 of a slot's command byte is 1 and the slot is not the last, the next slot's first low half follows the last falling edge directly and chip select stays low. If bit 7 is 0 and the slot is not the last, there is one low half period with chip select unchanged, then one half period with cs_n=4'hF, and then the next slot begins.
- R6: A run covers slots from the start pointer (word 0x00) up to and including the end pointer (word 0x01). After slot ENTRIES-1 the engine continues at slot 0.
- R7: Writing 1 to control bit 6 starts a run. The hardware clears that bit when the run ends, and in the same clock sets status bit 0. Writing 0 to the status word clears the flag; writing 1 leaves it unchanged.
- R8: While control bit 7 is 1, cs_n keeps the last slot's value after a run ends. Clearing bit 7 sets cs_n to 4'hF one clock after the register write.
- R9: Writing 1 to bit 0 of the lock word (0x05) holds chip select after runs in the same way. Writing 0 there releases it.
- R10: During a run, word 0x04 reads the number of the slot in progress.
- R11: While a run is active, bus writes to the pointers, the control word and the transmit and command slots have no effect.
- R12: A run lasts 16·`HALF_DIV` clocks for each slot. Each slot boundary without continue adds 2·`HALF_DIV`, and the final slot adds a trailing `HALF_DIV`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| sck | output | 1 | SPI clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The bench builds the block with `HALF_DIV` = 3, which makes every half period three clocks long. That way an off-by-one in the divider, the lead phase, the trail phase or the gap shows up as a misplaced cycle. `ENTRIES` stays at 16, so a run can be started near the top of the queue and the wrap back to slot 0 can be exercised. MISO is tied to the inverse of MOSI, which makes each received byte a known function of the transmitted one.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
  typedef enum logic [2:0] {
    EN_IDLE  = 3'd0,
    EN_LOW   = 3'd1,
    EN_HIGH  = 3'd2,
    EN_TRAIL = 3'd3,
    EN_GAP   = 3'd4
  } eng_state_t;

  localparam logic [1:0] RGN_CSR = 2'd0;
  localparam logic [1:0] RGN_TX  = 2'd1;
  localparam logic [1:0] RGN_RX  = 2'd2;
  localparam logic [1:0] RGN_CMD = 2'd3;

  localparam logic [2:0] CSR_STARTQ = 3'd0;
  localparam logic [2:0] CSR_LASTQ  = 3'd1;
  localparam logic [2:0] CSR_CTRL   = 3'd2;
  localparam logic [2:0] CSR_STAT   = 3'd3;
  localparam logic [2:0] CSR_CURQ   = 3'd4;
  localparam logic [2:0] CSR_LOCK   = 3'd5;

  localparam int CTRL_GO_BIT   = 6;
  localparam int CTRL_HOLD_BIT = 7;
  localparam int CMD_CONT_BIT  = 7;
endpackage

// File: rtl/spiq_regfile.sv
module spiq_regfile
  import spiq_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IW = $clog2(ENTRIES),
  localparam int AW = IW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          eng_busy,
  input  logic          eng_fin,
  input  logic [IW-1:0] eng_cur,
  input  logic [IW-1:0] rd_idx,
  input  logic          rx_we,
  input  logic [IW-1:0] rx_idx,
  input  logic [7:0]    rx_byte,
  output logic [7:0]    tx_byte,
  output logic [7:0]    cmd_byte,
  output logic [IW-1:0] start_q,
  output logic [IW-1:0] last_q,
  output logic          go,
  output logic          hold
);
  logic [1:0]    region;
  logic [IW:0]   slot;
  logic          csr_hit;
  logic          wr, wr_ok, active;
  logic [IW-1:0] startq_q, startq_d, lastq_q, lastq_d;
  logic          go_q, go_d, hold_q, hold_d, done_q, done_d, lock_q, lock_d;
  logic [7:0]    tx_mem  [ENTRIES];
  logic [7:0]    rx_mem  [ENTRIES];
  logic [7:0]    cmd_mem [ENTRIES];
  logic          tx_we, cmd_we;
  logic          unused_wdata;

  assign region  = bus_addr[AW-1:AW-2];
  assign slot    = bus_addr[IW:0];
  assign csr_hit = (region == RGN_CSR) && (slot[IW:3] == '0);
  assign wr      = bus_sel && bus_we;
  assign active  = go_q || eng_busy;
  assign wr_ok   = wr && !active;
  assign tx_we   = wr_ok && (region == RGN_TX) && !slot[0];
  assign cmd_we  = wr_ok && (region == RGN_CMD) && !slot[IW];
  assign unused_wdata = ^bus_wdata[31:8];

  always_comb begin
    startq_d = startq_q;
    lastq_d  = lastq_q;
    go_d     = go_q;
    hold_d   = hold_q;
    done_d   = done_q;
    lock_d   = lock_q;
    if (wr_ok && csr_hit && slot[2:0] == CSR_STARTQ) startq_d = bus_wdata[IW-1:0];
    if (wr_ok && csr_hit && slot[2:0] == CSR_LASTQ)  lastq_d  = bus_wdata[IW-1:0];
    if (wr_ok && csr_hit && slot[2:0] == CSR_CTRL) begin
      go_d   = bus_wdata[CTRL_GO_BIT];
      hold_d = bus_wdata[CTRL_HOLD_BIT];
    end
    if (eng_fin) go_d = 1'b0;
    if (wr && csr_hit && slot[2:0] == CSR_LOCK) lock_d = bus_wdata[0];
    if (eng_fin) done_d = 1'b1;
    else if (wr && csr_hit && slot[2:0] == CSR_STAT) done_d = done_q && bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      startq_q <= '0;
      lastq_q  <= '0;
      go_q     <= 1'b0;
      hold_q   <= 1'b0;
      done_q   <= 1'b0;
      lock_q   <= 1'b0;
    end else begin
      startq_q <= startq_d;
      lastq_q  <= lastq_d;
      go_q     <= go_d;
      hold_q   <= hold_d;
      done_q   <= done_d;
      lock_q   <= lock_d;
    end
  end

  always_ff @(posedge clk) begin
    if (tx_we) tx_mem[slot[IW:1]] <= bus_wdata[7:0];
  end

  always_ff @(posedge clk) begin
    if (cmd_we) cmd_mem[slot[IW-1:0]] <= bus_wdata[7:0];
  end

  always_ff @(posedge clk) begin
    if (rx_we) rx_mem[rx_idx] <= rx_byte;
  end

  always_comb begin
    bus_rdata = '0;
    unique case (region)
      RGN_CSR: if (csr_hit) begin
        case (slot[2:0])
          CSR_STARTQ: bus_rdata[IW-1:0] = startq_q;
          CSR_LASTQ:  bus_rdata[IW-1:0] = lastq_q;
          CSR_CTRL: begin
            bus_rdata[CTRL_GO_BIT]   = go_q;
            bus_rdata[CTRL_HOLD_BIT] = hold_q;
          end
          CSR_STAT:   bus_rdata[0]      = done_q;
          CSR_CURQ:   bus_rdata[IW-1:0] = eng_cur;
          CSR_LOCK:   bus_rdata[0]      = lock_q;
          default:    bus_rdata = '0;
        endcase
      end
      RGN_TX:  if (!slot[0])  bus_rdata[7:0] = tx_mem[slot[IW:1]];
      RGN_RX:  if (slot[0])   bus_rdata[7:0] = rx_mem[slot[IW:1]];
      RGN_CMD: if (!slot[IW]) bus_rdata[7:0] = cmd_mem[slot[IW-1:0]];
      default: bus_rdata = '0;
    endcase
  end

  assign tx_byte  = tx_mem[rd_idx];
  assign cmd_byte = cmd_mem[rd_idx];
  assign start_q  = startq_q;
  assign last_q   = lastq_q;
  assign go       = go_q;
  assign hold     = hold_q || lock_q;

  // R7
  done_after_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_fin |=> (done_q && !go_q));

  // R11
  ptr_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && active && csr_hit && slot[2:0] == CSR_STARTQ) |=> $stable(startq_q));

  // R11
  go_no_rewrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && !eng_fin) |=> go_q);
endmodule

// File: rtl/spiq_engine.sv
module spiq_engine
  import spiq_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int HALF_DIV = 2,
  localparam int IW = $clog2(ENTRIES),
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          hold,
  input  logic [IW-1:0] start_q,
  input  logic [IW-1:0] last_q,
  input  logic [7:0]    tx_byte,
  input  logic [7:0]    cmd_byte,
  input  logic          miso,
  output logic [IW-1:0] rd_idx,
  output logic [IW-1:0] cur,
  output logic          busy,
  output logic          fin,
  output logic          rx_we,
  output logic [7:0]    rx_byte,
  output logic          sck,
  output logic          mosi,
  output logic [3:0]    cs_n
);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF_DIV - 1);

  eng_state_t    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    bit_q, bit_d;
  logic [IW-1:0] cur_q, cur_d, nxt_idx;
  logic [7:0]    txsh_q, txsh_d, rxsh_q, rxsh_d, cmd_q, cmd_d;
  logic [3:0]    cs_q, cs_d;
  logic          sck_q, sck_d;
  logic          tick, at_last;
  logic          unused_cmd;

  assign tick    = (cnt_q == '0);
  assign at_last = (cur_q == last_q);
  assign nxt_idx = cur_q + 1'b1;
  assign rd_idx  = (st_q == EN_IDLE) ? start_q : nxt_idx;
  assign unused_cmd = ^cmd_q[6:4];

  always_comb begin
    st_d   = st_q;
    cnt_d  = tick ? HALF_LAST : cnt_q - 1'b1;
    bit_d  = bit_q;
    cur_d  = cur_q;
    txsh_d = txsh_q;
    rxsh_d = rxsh_q;
    cmd_d  = cmd_q;
    cs_d   = cs_q;
    sck_d  = sck_q;
    fin    = 1'b0;
    rx_we  = 1'b0;
    unique case (st_q)
      EN_IDLE: begin
        cnt_d = HALF_LAST;
        if (go) begin
          cur_d  = start_q;
          cmd_d  = cmd_byte;
          txsh_d = tx_byte;
          cs_d   = cmd_byte[3:0];
          bit_d  = 3'd7;
          st_d   = EN_LOW;
        end else if (!hold) begin
          cs_d = 4'hF;
        end
      end
      EN_LOW: if (tick) begin
        sck_d  = 1'b1;
        rxsh_d = {rxsh_q[6:0], miso};
        st_d   = EN_HIGH;
      end
      EN_HIGH: if (tick) begin
        sck_d = 1'b0;
        if (bit_q != 3'd0) begin
          bit_d  = bit_q - 1'b1;
          txsh_d = {txsh_q[6:0], 1'b0};
          st_d   = EN_LOW;
        end else begin
          rx_we = 1'b1;
          if (cmd_q[CMD_CONT_BIT] && !at_last) begin
            cur_d  = nxt_idx;
            cmd_d  = cmd_byte;
            txsh_d = tx_byte;
            cs_d   = cmd_byte[3:0];
            bit_d  = 3'd7;
            st_d   = EN_LOW;
          end else begin
            st_d = EN_TRAIL;
          end
        end
      end
      EN_TRAIL: if (tick) begin
        if (at_last) begin
          fin  = 1'b1;
          st_d = EN_IDLE;
          if (!hold) cs_d = 4'hF;
        end else begin
          cs_d   = 4'hF;
          cur_d  = nxt_idx;
          cmd_d  = cmd_byte;
          txsh_d = tx_byte;
          bit_d  = 3'd7;
          st_d   = EN_GAP;
        end
      end
      EN_GAP: if (tick) begin
        cs_d = cmd_q[3:0];
        st_d = EN_LOW;
      end
      default: st_d = EN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= EN_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      cur_q  <= '0;
      txsh_q <= '0;
      rxsh_q <= '0;
      cmd_q  <= '0;
      cs_q   <= 4'hF;
      sck_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      cur_q  <= cur_d;
      txsh_q <= txsh_d;
      rxsh_q <= rxsh_d;
      cmd_q  <= cmd_d;
      cs_q   <= cs_d;
      sck_q  <= sck_d;
    end
  end

  assign cur     = cur_q;
  assign busy    = (st_q != EN_IDLE);
  assign rx_byte = rxsh_q;
  assign sck     = sck_q;
  assign mosi    = txsh_q[7];
  assign cs_n    = cs_q;

  // R2
  sck_rest_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);

  // R7
  fin_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);

  // R3
  rx_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> (busy && sck));

  // R9
  release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go && !hold) |=> (cs_n == 4'hF));

  // R2
  sel_during_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> ($countones(~cs_n) >= 1));
endmodule

// File: rtl/spiq_master.sv
module spiq_master #(
  parameter int ENTRIES  = 16,
  parameter int HALF_DIV = 2,
  localparam int IW = $clog2(ENTRIES),
  localparam int AW = IW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          sck,
  output logic          mosi,
  input  logic          miso,
  output logic [3:0]    cs_n
);
  logic          rst_s1, rst_sync;
  logic          busy, fin, rx_we, go, hold;
  logic [IW-1:0] cur, rd_idx, rx_idx, start_q, last_q;
  logic [7:0]    tx_byte, cmd_byte, rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1   <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_s1   <= 1'b1;
      rst_sync <= rst_s1;
    end
  end

  assign rx_idx = cur;

  spiq_regfile #(.ENTRIES(ENTRIES)) u_regs (
    .clk(clk), .rst_n(rst_sync),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_busy(busy), .eng_fin(fin), .eng_cur(cur), .rd_idx(rd_idx),
    .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte),
    .tx_byte(tx_byte), .cmd_byte(cmd_byte),
    .start_q(start_q), .last_q(last_q), .go(go), .hold(hold)
  );

  spiq_engine #(.ENTRIES(ENTRIES), .HALF_DIV(HALF_DIV)) u_eng (
    .clk(clk), .rst_n(rst_sync),
    .go(go), .hold(hold), .start_q(start_q), .last_q(last_q),
    .tx_byte(tx_byte), .cmd_byte(cmd_byte), .miso(miso),
    .rd_idx(rd_idx), .cur(cur), .busy(busy), .fin(fin),
    .rx_we(rx_we), .rx_byte(rx_byte),
    .sck(sck), .mosi(mosi), .cs_n(cs_n)
  );
endmodule

// File: tb/sim_spiq_master.sv
module sim_spiq_master;
  localparam int H = 3;
  localparam int E = 16;

  logic        clk, rst_n, bus_sel, bus_we, miso, sck, mosi;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  cs_n;
  int          n_chk, n_err;
  logic [7:0]  txm [E];
  logic [7:0]  cmdm[E];
  logic [6:0]  exq [$];
  logic [31:0] rd;

  spiq_master #(.ENTRIES(E), .HALF_DIV(H)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  assign miso = ~mosi;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [6:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  // reference waveform: {cs[3:0], sck, mosi, mosi_valid}
  task automatic build(input int sp, input int lp);
    int i = sp;
    exq.delete();
    forever begin
      for (int b = 7; b >= 0; b--) begin
        for (int k = 0; k < H; k++) exq.push_back({cmdm[i][3:0], 1'b0, txm[i][b], 1'b1});
        for (int k = 0; k < H; k++) exq.push_back({cmdm[i][3:0], 1'b1, txm[i][b], 1'b1});
      end
      if (i == lp) begin
        for (int k = 0; k < H; k++) exq.push_back({cmdm[i][3:0], 1'b0, 1'b0, 1'b0});
        break;
      end
      if (!cmdm[i][7]) begin
        for (int k = 0; k < H; k++) exq.push_back({cmdm[i][3:0], 1'b0, 1'b0, 1'b0});
        for (int k = 0; k < H; k++) exq.push_back({4'hF, 1'b0, 1'b0, 1'b0});
      end
      i = (i + 1) % E;
    end
  endtask

  task automatic compare_run(input string tag);
    for (int c = 0; c < exq.size(); c++) begin
      @(negedge clk);
      check(cs_n == exq[c][6:3] && sck == exq[c][2] && (!exq[c][0] || mosi == exq[c][1]),
            tag, {20'd0, c[3:0], cs_n, 1'b0, sck, mosi, 1'b0},
            {20'd0, c[3:0], exq[c][6:3], 1'b0, exq[c][2], exq[c][1], 1'b0});
    end
  endtask

  task automatic start_run(input int sp, input int lp, input logic [31:0] ctrl);
    bus_write(7'h00, sp);
    bus_write(7'h01, lp);
    build(sp, lp);
    bus_write(7'h02, ctrl);
  endtask

  task automatic check_rx(input int sp, input int lp, input string tag);
    int i = sp;
    forever begin
      bus_read(7'h40 + 7'(2*i+1), rd);
      check(rd[7:0] == ~txm[i], tag, rd, {24'd0, ~txm[i]});
      if (i == lp) break;
      i = (i + 1) % E;
    end
  endtask

  task automatic check_done(input string tag);
    @(negedge clk);
    bus_read(7'h03, rd);
    check(rd[0] == 1'b1, {tag, " done flag"}, rd, 1);
    bus_read(7'h02, rd);
    check(rd[6] == 1'b0, {tag, " go cleared"}, rd, 0);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_err++;
    $display("FAIL watchdog expired act=%h exp=%h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0;
    bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(cs_n == 4'hF, "R1 cs_n", cs_n, 4'hF);
    check(sck == 1'b0, "R1 sck", sck, 0);
    bus_read(7'h02, rd); check(rd == 0, "R1 ctrl", rd, 0);
    bus_read(7'h03, rd); check(rd == 0, "R1 status", rd, 0);
    bus_read(7'h04, rd); check(rd == 0, "R1 cur slot", rd, 0);

    for (int i = 0; i < E; i++) begin
      txm[i]  = 8'((i * 37 + 5) ^ 8'hA6);
      cmdm[i] = 8'h0E;
    end
    cmdm[4] = 8'h8D; cmdm[5] = 8'h8D; cmdm[6] = 8'h0D;
    cmdm[8] = 8'h0B; cmdm[9] = 8'h07;
    cmdm[14] = 8'h8E; cmdm[15] = 8'h0B; cmdm[0] = 8'h8D; cmdm[1] = 8'h07;
    for (int i = 0; i < E; i++) begin
      bus_write(7'h20 + 7'(2*i), {24'd0, txm[i]});
      bus_write(7'h60 + 7'(i), {24'd0, cmdm[i]});
    end
    bus_read(7'h20 + 7'd6, rd); check(rd[7:0] == txm[3], "R3 tx slot readback", rd, txm[3]);

    // R2 R12 single slot
    start_run(3, 3, 32'h40); compare_run("R2 single slot");
    check_done("R7"); check_rx(3, 3, "R3 rx slot");
    bus_write(7'h03, 32'h1); bus_read(7'h03, rd); check(rd[0] == 1, "R7 write 1 keeps flag", rd, 1);
    bus_write(7'h03, 32'h0); bus_read(7'h03, rd); check(rd[0] == 0, "R7 write 0 clears flag", rd, 0);

    // R5 continued slots
    start_run(4, 6, 32'h40); compare_run("R5 continue chain");
    check_done("R5"); check_rx(4, 6, "R3 rx chain");
    bus_write(7'h03, 0);

    // R4 R5 gap between separate selects
    start_run(8, 9, 32'h40); compare_run("R4 per-slot select with gap");
    check_done("R4"); check_rx(8, 9, "R3 rx pair");
    bus_write(7'h03, 0);

    // R6 wrap
    start_run(14, 1, 32'h40); compare_run("R6 wrap 14..1");
    check_done("R6"); check_rx(14, 1, "R6 rx wrap");
    bus_write(7'h03, 0);

    // R8 hold via control bit 7
    start_run(2, 2, 32'hC0); compare_run("R8 held run");
    @(negedge clk); check(cs_n == cmdm[2][3:0], "R8 cs held after run", cs_n, cmdm[2][3:0]);
    repeat (5) @(negedge clk);
    check(cs_n == cmdm[2][3:0], "R8 cs still held", cs_n, cmdm[2][3:0]);
    bus_write(7'h02, 32'h0);
    @(negedge clk); check(cs_n == 4'hF, "R8 release", cs_n, 4'hF);
    bus_write(7'h03, 0);

    // R9 lock register
    bus_write(7'h05, 32'h1);
    start_run(8, 8, 32'h40); compare_run("R9 locked run");
    @(negedge clk); check(cs_n == cmdm[8][3:0], "R9 cs locked", cs_n, cmdm[8][3:0]);
    bus_write(7'h05, 32'h0);
    @(negedge clk); check(cs_n == 4'hF, "R9 unlock release", cs_n, 4'hF);
    bus_write(7'h03, 0);

    // R10 R11 activity during a run
    start_run(10, 12, 32'h40);
    fork
      compare_run("R10 run 10..12");
      begin
        repeat (20) @(negedge clk);
        bus_read(7'h04, rd); check(rd == 10, "R10 cur slot first", rd, 10);
        bus_write(7'h00, 32'h0);
        bus_write(7'h20 + 7'd20, 32'h00);
        bus_write(7'h60 + 7'd11, 32'h0F);
        repeat (55) @(negedge clk);
        bus_read(7'h04, rd); check(rd == 11, "R10 cur slot second", rd, 11);
      end
    join
    check_done("R11");
    bus_read(7'h00, rd); check(rd == 10, "R11 pointer write ignored", rd, 10);
    bus_read(7'h20 + 7'd20, rd); check(rd[7:0] == txm[10], "R11 tx write ignored", rd, txm[10]);
    bus_read(7'h60 + 7'd11, rd); check(rd[7:0] == cmdm[11], "R11 cmd write ignored", rd, cmdm[11]);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule